// File: doc/BRIEF.md
# Serial In-System Programming Target

This block is the target end of a four-wire serial programming port for a small microcontroller. While the external programming reset input is held low, it watches a serial clock and a serial data input, collects fixed 4-byte instructions most-significant bit first, and answers on a serial data output. It owns two storage arrays modelled as registers: a program store of 4096 words of 16 bits and a data store of 512 bytes.

The serial clock is never used as a clock. It is synchronised into the fast system clock domain and its edges are found by oversampling. Each of its high and low phases must therefore last longer than two system clocks. The port first has to be unlocked by an enable instruction. While that instruction arrives in step, its second byte comes back during the third byte slot, so the host can check that it is in sync. Once the port is unlocked, the host can erase both arrays, read and write either byte of a program word, and read and write data-store bytes. Every write or erase holds the port busy for a while, and instructions that arrive in that time are dropped.

Top module: `isp_slave`

## Requirements
- R1: The port acts only while `ext_rst_n` is low. Raising it drops any partly received instruction, locks the port again and drives `miso` to 0. The next instruction is then framed from its first bit.
- R2: Until an enable instruction (bytes 0xAC, 0x53, any, any) has completed, every read returns 0x00 and every write or erase leaves both arrays unchanged.
- R3: An instruction is 32 bits, taken MSB first, and `mosi` is sampled on each rising edge of `sck`. Both signals pass through a two-flop synchroniser, so each `sck` phase must last more than 2 system clocks.
- R4: `miso` changes only after a falling edge of `sck`. Each reply byte is sent MSB first, and every byte slot with no defined reply carries 0x00.
- R5: When the first two bytes are 0xAC 0x53, the third byte slot returns 0x53. For any other first pair, that slot returns 0x00.
- R6: Opcodes 0x20 and 0x28 return, in the fourth byte slot, the low or high byte of the program word at address {byte2[3:0], byte3}.
- R7: Opcodes 0x40 and 0x48 write byte 4 into the low or high byte of the addressed program word. The other byte of that word is left as it was.
- R8: Opcode 0xA0 returns the data-store byte at address {byte2[0], byte3} in the fourth slot. Opcode 0xC0 replaces that byte with byte 4 in full, with no erase needed first.
- R9: Bytes 0xAC 0x80 start a chip erase. The erase sets every location of both arrays to 0xFF, one location per system clock, and the port stays busy until the sweep is done.
- R10: After any write, the port is busy for `BUSY_CYC` system clocks. A read, write or erase that completes in that time is ignored, and a read then returns 0x00.
- R11: An instruction with any other opcode changes nothing, and its reply slots carry 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | Programming reset; the port is active while this is low |
| sck | input | 1 | Serial clock from the programmer |
| mosi | input | 1 | Serial data into the target |
| miso | output | 1 | Serial data out of the target |

## Verification
The bench sends an enable instruction whose second byte is wrong and then tries a read. A design that only checked the first byte would unlock and return data. It also writes and reads while the port is locked or busy, so a design that ignored the lock or dropped the busy window would store the value or return a real byte where 0x00 is expected. It writes only the high byte of a program word and then reads the low byte, and it overwrites a data-store byte, so a write that touched the wrong byte or merged bits instead of replacing them would show up. It also raises the programming reset in the middle of an instruction. A bit counter that carried over across that event would misframe the next instruction, and an enable flag that survived it would let a locked read return data.

// File: rtl/isp_slave.sv
module isp_slave #(
  parameter int PAW      = 12,
  parameter int EAW      = 9,
  parameter int BUSY_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_rst_n,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  localparam int BCW = $clog2(BUSY_CYC + 1);

  logic [15:0] pmem [0:(1<<PAW)-1];
  logic [7:0]  emem [0:(1<<EAW)-1];

  logic [2:0]     sck_q;
  logic [1:0]     mosi_q, xr_q;
  logic [4:0]     bcnt;
  logic [30:0]    sh;
  logic [7:0]     tx;
  logic           enabled, erasing;
  logic [BCW-1:0] busy_cnt;
  logic [PAW-1:0] ecnt;
  logic [7:0]     rd_byte;

  wire active   = ~xr_q[1];
  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire sck_fall = ~sck_q[1] & sck_q[2];
  wire [31:0] word = {sh, mosi_q[1]};
  wire busy     = erasing | (busy_cnt != '0);
  wire cmd_exec = active & sck_rise & (bcnt == 5'd31);
  wire cmd_ok   = cmd_exec & enabled & ~busy;
  wire [PAW-1:0] w_paddr = word[PAW+7:8];
  wire [EAW-1:0] w_eaddr = word[EAW+7:8];
  wire wr_plo   = cmd_ok & (word[31:24] == 8'h40);
  wire wr_phi   = cmd_ok & (word[31:24] == 8'h48);
  wire wr_ee    = cmd_ok & (word[31:24] == 8'hC0);
  wire erase_go = cmd_ok & (word[31:16] == 16'hAC80);
  wire go_en    = cmd_exec & (word[31:16] == 16'hAC53);

  always_comb begin
    rd_byte = 8'h00;
    if (enabled && !busy) begin
      case (word[23:16])
        8'h20:   rd_byte = pmem[word[PAW-1:0]][7:0];
        8'h28:   rd_byte = pmem[word[PAW-1:0]][15:8];
        8'hA0:   rd_byte = emem[word[EAW-1:0]];
        default: rd_byte = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= '0;
      mosi_q <= '0;
      xr_q   <= 2'b11;
    end else begin
      sck_q  <= {sck_q[1:0], sck};
      mosi_q <= {mosi_q[0], mosi};
      xr_q   <= {xr_q[0], ext_rst_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt     <= '0;
      sh       <= '0;
      tx       <= '0;
      miso     <= 1'b0;
      enabled  <= 1'b0;
      busy_cnt <= '0;
      erasing  <= 1'b0;
      ecnt     <= '0;
    end else begin
      if (busy_cnt != '0) busy_cnt <= busy_cnt - BCW'(1);
      if (erasing) begin
        ecnt <= ecnt + PAW'(1);
        if (&ecnt) erasing <= 1'b0;
      end
      if (wr_plo || wr_phi || wr_ee) busy_cnt <= BCW'(BUSY_CYC);
      if (erase_go) begin
        erasing <= 1'b1;
        ecnt    <= '0;
      end
      if (!active) begin
        bcnt    <= '0;
        sh      <= '0;
        tx      <= '0;
        miso    <= 1'b0;
        enabled <= 1'b0;
      end else begin
        if (sck_fall) begin
          miso <= tx[7];
          tx   <= {tx[6:0], 1'b0};
        end
        if (sck_rise) begin
          sh   <= word[30:0];
          bcnt <= bcnt + 5'd1;
          if (bcnt[2:0] == 3'd7) begin
            case (bcnt[4:3])
              2'd1:    tx <= (word[15:0] == 16'hAC53) ? word[7:0] : 8'h00;
              2'd2:    tx <= rd_byte;
              default: tx <= 8'h00;
            endcase
          end
        end
        if (go_en) enabled <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (erasing) begin
      pmem[ecnt] <= 16'hFFFF;
      if ((ecnt >> EAW) == '0) emem[ecnt[EAW-1:0]] <= 8'hFF;
    end else begin
      if (wr_plo) pmem[w_paddr][7:0]  <= word[7:0];
      if (wr_phi) pmem[w_paddr][15:8] <= word[7:0];
      if (wr_ee)  emem[w_eaddr]       <= word[7:0];
    end
  end
endmodule

module isp_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       active,
  input logic       sck_rise,
  input logic       sck_fall,
  input logic       miso,
  input logic       enabled,
  input logic [4:0] bcnt,
  input logic       busy,
  input logic       cmd_exec
);
  assert_lock_on_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!enabled && bcnt == 5'd0));
  assert_enable_after_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enabled) |-> ($past(sck_rise) && $past(bcnt) == 5'd31));
  assert_count_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sck_rise) |=> $stable(bcnt));
  assert_miso_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sck_fall) |=> $stable(miso));
  assert_busy_from_command_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_exec));
endmodule

bind isp_slave isp_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .sck_rise(sck_rise),
  .sck_fall(sck_fall), .miso(miso), .enabled(enabled), .bcnt(bcnt),
  .busy(busy), .cmd_exec(cmd_exec)
);

// File: tb/isp_slave_test.sv
module isp_slave_test;
  logic clk = 1'b0, rst_n = 1'b0, ext_rst_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  wire  miso;
  always #5 clk = ~clk;

  isp_slave #(.BUSY_CYC(400)) uut (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_rst_n),
    .sck(sck), .mosi(mosi), .miso(miso)
  );

  typedef struct { logic [7:0] s3; logic [7:0] s4; string tag; } exp_t;
  exp_t        q[$];
  int          total = 0, bad = 0;
  logic [31:0] cap;
  logic [7:0]  got3, got4;
  bit          r4_bad = 0;
  event        done_ev;

  task automatic check(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic clocks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift(int n, logic [31:0] w);
    logic mh;
    for (int i = 0; i < n; i++) begin
      mosi = w[31-i];
      clocks(5);
      cap = {cap[30:0], miso};
      mh  = miso;
      sck = 1'b1;
      clocks(5);
      if (miso !== mh) r4_bad = 1;
      sck = 1'b0;
    end
  endtask

  task automatic xfer(logic [7:0] b0, b1, b2, b3, logic [7:0] e3, e4, string tag);
    exp_t e;
    e.s3 = e3; e.s4 = e4; e.tag = tag;
    q.push_back(e);
    shift(32, {b0, b1, b2, b3});
    got3 = cap[15:8];
    got4 = cap[7:0];
    ->done_ev;
    clocks(10);
  endtask

  initial begin
    forever begin
      exp_t e;
      @(done_ev);
      e = q.pop_front();
      check(got3 === e.s3, {e.tag, " slot3"}, got3, e.s3);
      check(got4 === e.s4, {e.tag, " slot4"}, got4, e.s4);
    end
  end

  task automatic finish_up;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    clocks(3);
    rst_n = 1'b1;
    clocks(3);
    check(miso === 1'b0, "R1 idle miso after reset", miso, 0);
    ext_rst_n = 1'b0;
    clocks(5);

    xfer(8'h40, 8'h00, 8'h05, 8'h12, 8'h00, 8'h00, "R2 write while locked");
    clocks(500);
    xfer(8'hA0, 8'h01, 8'hFF, 8'h00, 8'h00, 8'h00, "R2 read while locked");
    xfer(8'hAC, 8'h54, 8'h00, 8'h00, 8'h00, 8'h00, "R5 wrong enable no echo");
    xfer(8'hA0, 8'h01, 8'hFF, 8'h00, 8'h00, 8'h00, "R2 still locked");
    xfer(8'hAC, 8'h53, 8'h00, 8'h00, 8'h53, 8'h00, "R5 enable echo");
    xfer(8'hAC, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00, "R9 erase");
    clocks(4300);
    xfer(8'h20, 8'h00, 8'h05, 8'h00, 8'h00, 8'hFF, "R2 locked write dropped, R9 erased");
    xfer(8'hA0, 8'h01, 8'hFF, 8'h00, 8'h00, 8'hFF, "R9 R3 top data byte erased");

    xfer(8'h40, 8'h01, 8'h23, 8'hA5, 8'h00, 8'h00, "R7 write low");
    clocks(500);
    xfer(8'h48, 8'h01, 8'h23, 8'h3C, 8'h00, 8'h00, "R7 write high");
    clocks(500);
    xfer(8'h20, 8'h01, 8'h23, 8'h00, 8'h00, 8'hA5, "R6 R7 low byte kept");
    xfer(8'h28, 8'h01, 8'h23, 8'h00, 8'h00, 8'h3C, "R6 high byte");
    xfer(8'h28, 8'h00, 8'h05, 8'h00, 8'h00, 8'hFF, "R6 other word untouched");

    xfer(8'hC0, 8'h01, 8'h00, 8'h5A, 8'h00, 8'h00, "R8 write data");
    clocks(500);
    xfer(8'hC0, 8'h01, 8'h00, 8'h0F, 8'h00, 8'h00, "R8 overwrite");
    clocks(500);
    xfer(8'hA0, 8'h01, 8'h00, 8'h00, 8'h00, 8'h0F, "R8 full replace");

    xfer(8'hC0, 8'h00, 8'h10, 8'h77, 8'h00, 8'h00, "R10 first write");
    xfer(8'hC0, 8'h00, 8'h11, 8'h99, 8'h00, 8'h00, "R10 write while busy");
    clocks(500);
    xfer(8'hA0, 8'h00, 8'h10, 8'h00, 8'h00, 8'h77, "R10 first write stored");
    xfer(8'hA0, 8'h00, 8'h11, 8'h00, 8'h00, 8'hFF, "R10 busy write dropped");
    xfer(8'hC0, 8'h00, 8'h12, 8'h55, 8'h00, 8'h00, "R10 write then read");
    xfer(8'hA0, 8'h00, 8'h12, 8'h00, 8'h00, 8'h00, "R10 read while busy");
    clocks(500);

    xfer(8'h55, 8'h01, 8'h23, 8'h00, 8'h00, 8'h00, "R11 unknown opcode");
    xfer(8'h20, 8'h01, 8'h23, 8'h00, 8'h00, 8'hA5, "R11 no side effect");

    shift(12, 32'h20_01_23_00);
    ext_rst_n = 1'b1;
    clocks(10);
    check(miso === 1'b0, "R1 miso low on release", miso, 0);
    ext_rst_n = 1'b0;
    clocks(5);
    xfer(8'h20, 8'h01, 8'h23, 8'h00, 8'h00, 8'h00, "R1 lock restored");
    xfer(8'hAC, 8'h53, 8'h11, 8'h22, 8'h53, 8'h00, "R1 R5 re-enable");
    xfer(8'h20, 8'h01, 8'h23, 8'h00, 8'h00, 8'hA5, "R1 framing restarted");

    check(!r4_bad, "R4 miso steady while sck high", r4_bad, 0);
    clocks(20);
    finish_up();
  end
endmodule